// File: doc/BRIEF.md
# PLL Feedback Divider Ramp Controller

This controller moves the feedback divider of a running PLL to a new value through the PLL's own gradual ramp hardware, so the output frequency glides instead of jumping. A caller gives it a one-cycle start pulse, the wanted divider value and the coefficient word that is programmed now. The controller then runs a fixed sequence. It loads the two ramp step sizes and enters slowdown mode. One microsecond later it writes the new coefficient word, and one microsecond after that it enables the ramp. It then checks the synchronized ramp-complete flag once per microsecond.

When the ramp completes, or when the poll budget runs out, the controller clears the slowdown and ramp-enable controls together. On the next cycle it gives a single-cycle success or timeout pulse. If the requested divider equals the one already programmed, the controller leaves every control output as it is and reports success at once. Microseconds are measured with a prescaler of `CLK_HZ / 1_000_000` cycles.

Top module: `pll_ndiv_ramp_ctrl`

## Requirements
- R1: After reset, every output is 0: both step sizes, the slowdown bit, the ramp enable, the write strobe, the coefficient output, busy, done and timeout.
- R2: When start arrives while idle and the requested divider equals bits [15:8] of the current coefficient word, done pulses for one cycle after that edge. Busy stays low, and no control output or coefficient output changes.
- R3: In any other case, step A becomes 0x2B and step B becomes 0x0B one cycle after start. The slowdown bit rises one cycle after that.
- R4: Exactly U cycles after the slowdown bit rises (U = CLK_HZ/1e6), the write strobe pulses for one cycle. The coefficient output then holds the input word with bits [15:8] replaced by the new divider. Bits [7:0] (reference divider) and bits [21:16] (post divider) are kept.
- R5: The ramp enable rises exactly U cycles after the write strobe.
- R6: The ramp-complete input is sampled every U cycles, starting U cycles after the ramp enable rises. At most POLL_LIMIT (default 500) samples are taken. If none of them is high, timeout pulses for one cycle instead of done.
- R7: The slowdown bit and the ramp enable both fall on the same edge: the edge of the first high sample, or of the last unsuccessful sample.
- R8: Done (on success) or timeout (on failure) pulses for exactly one cycle, one cycle after the controls are cleared. Busy drops on that same edge. Done and timeout are never high together.
- R9: A start pulse while busy is ignored. The sequence timing and the written coefficient word are unaffected.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin a divider change |
| target_n | input | 8 | Requested feedback divider |
| coeff_cur | input | 22 | Currently programmed coefficient word |
| ramp_done_sync | input | 1 | Synchronized ramp-complete flag |
| step_a | output | 8 | Ramp step size A |
| step_b | output | 8 | Ramp step size B |
| slowdown_en | output | 1 | Slowdown-using-PLL mode |
| ramp_en | output | 1 | Dynamic ramp enable |
| coeff_wdata | output | 22 | Coefficient word to program |
| coeff_wr | output | 1 | One-cycle write strobe for coeff_wdata |
| busy | output | 1 | Sequence in progress |
| done | output | 1 | Success pulse |
| timeout | output | 1 | Poll budget exhausted pulse |

## Verification
The hardest cases sit at the edges of the poll budget. These are a ramp-complete flag that first appears at the very last permitted sample, and one that appears a single cycle too late for it. Both need the flag to rise at an exact cycle, about two thousand cycles after start. The bench models the PLL ramp itself and raises the flag a chosen number of cycles after the enable rises. It sweeps that delay across prescaler phase boundaries, around the 499th/500th/501st sample, and with the flag never rising. It derives the expected sample index and exit cycle for each delay by arithmetic.

// File: rtl/pll_ndiv_ramp_ctrl.sv
module pll_ndiv_ramp_ctrl #(
  parameter int          CLK_HZ     = 125_000_000,
  parameter int          POLL_LIMIT = 500,
  parameter int          M_W        = 8,
  parameter int          N_W        = 8,
  parameter int          PL_W       = 6,
  parameter logic [7:0]  STEP_A_VAL = 8'h2B,
  parameter logic [7:0]  STEP_B_VAL = 8'h0B
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      start,
  input  logic [N_W-1:0]            target_n,
  input  logic [M_W+N_W+PL_W-1:0]   coeff_cur,
  input  logic                      ramp_done_sync,
  output logic [7:0]                step_a,
  output logic [7:0]                step_b,
  output logic                      slowdown_en,
  output logic                      ramp_en,
  output logic [M_W+N_W+PL_W-1:0]   coeff_wdata,
  output logic                      coeff_wr,
  output logic                      busy,
  output logic                      done,
  output logic                      timeout
);
  localparam int CW     = M_W + N_W + PL_W;
  localparam int N_LSB  = M_W;
  localparam int US_CYC = (CLK_HZ / 1_000_000) < 1 ? 1 : CLK_HZ / 1_000_000;
  localparam int UC_W   = $clog2(US_CYC + 1);
  localparam int PC_W   = $clog2(POLL_LIMIT + 1);
  localparam logic [UC_W-1:0] US_RELOAD = UC_W'(US_CYC - 1);
  localparam logic [PC_W-1:0] POLL_LAST = PC_W'(POLL_LIMIT - 1);

  typedef enum logic [2:0] {S_IDLE, S_STEPS, S_SLOW, S_WAIT_N, S_WAIT_EN, S_POLL, S_FIN} st_t;

  st_t              st;
  logic [UC_W-1:0]  us_cnt;
  logic [PC_W-1:0]  polls;
  logic [N_W-1:0]   n_req;
  logic [CW-1:0]    base;
  logic             ok;

  wire tick = (us_cnt == '0);
  wire same = (target_n == coeff_cur[N_LSB +: N_W]);
  wire [CW-1:0] new_word = {base[CW-1:N_LSB+N_W], n_req, base[M_W-1:0]};

  assign busy = (st != S_IDLE);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st          <= S_IDLE;
      us_cnt      <= '0;
      polls       <= '0;
      n_req       <= '0;
      base        <= '0;
      ok          <= 1'b0;
      step_a      <= '0;
      step_b      <= '0;
      slowdown_en <= 1'b0;
      ramp_en     <= 1'b0;
      coeff_wdata <= '0;
      coeff_wr    <= 1'b0;
      done        <= 1'b0;
      timeout     <= 1'b0;
    end else begin
      coeff_wr <= 1'b0;
      done     <= 1'b0;
      timeout  <= 1'b0;
      case (st)
        S_IDLE: if (start) begin
          n_req <= target_n;
          base  <= coeff_cur;
          if (same) done <= 1'b1;
          else      st   <= S_STEPS;
        end
        S_STEPS: begin
          step_a <= STEP_A_VAL;
          step_b <= STEP_B_VAL;
          st     <= S_SLOW;
        end
        S_SLOW: begin
          slowdown_en <= 1'b1;
          us_cnt      <= US_RELOAD;
          st          <= S_WAIT_N;
        end
        S_WAIT_N: if (tick) begin
          coeff_wdata <= new_word;
          coeff_wr    <= 1'b1;
          us_cnt      <= US_RELOAD;
          st          <= S_WAIT_EN;
        end else us_cnt <= us_cnt - 1'b1;
        S_WAIT_EN: if (tick) begin
          ramp_en <= 1'b1;
          polls   <= '0;
          us_cnt  <= US_RELOAD;
          st      <= S_POLL;
        end else us_cnt <= us_cnt - 1'b1;
        S_POLL: if (tick) begin
          us_cnt <= US_RELOAD;
          if (ramp_done_sync || polls == POLL_LAST) begin
            ok          <= ramp_done_sync;
            slowdown_en <= 1'b0;
            ramp_en     <= 1'b0;
            st          <= S_FIN;
          end else polls <= polls + 1'b1;
        end else us_cnt <= us_cnt - 1'b1;
        S_FIN: begin
          done    <= ok;
          timeout <= !ok;
          st      <= S_IDLE;
        end
        default: st <= S_IDLE;
      endcase
    end
  end

  a_r2_skip_done: assert property (@(posedge clk) disable iff (!rst_n)
    (start && !busy && same) |=> (done && !busy && !coeff_wr));
  a_r3_slow_after_steps: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(slowdown_en) |-> (step_a == STEP_A_VAL && step_b == STEP_B_VAL));
  a_r4_write_in_slowdown: assert property (@(posedge clk) disable iff (!rst_n)
    coeff_wr |-> (slowdown_en && !ramp_en && !$past(coeff_wr)));
  a_r5_ramp_needs_slowdown: assert property (@(posedge clk) disable iff (!rst_n)
    ramp_en |-> slowdown_en);
  a_r7_clear_together: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(slowdown_en) |-> $fell(ramp_en));
  a_r8_report_after_clear: assert property (@(posedge clk) disable iff (!rst_n)
    (done || timeout) |-> (!slowdown_en && !ramp_en && !busy));
  a_r8_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({done, timeout}));
  a_r9_word_held: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !coeff_wr) |=> (coeff_wr || $stable(coeff_wdata)));
endmodule

// File: tb/test_pll_ndiv_ramp_ctrl.sv
module test_pll_ndiv_ramp_ctrl;
  localparam int CLK_HZ = 4_000_000;
  localparam int U      = 4;
  localparam int LIM    = 500;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0;
  logic [7:0]  target_n = '0;
  logic [21:0] coeff_cur = '0;
  logic        ramp_done_sync = 1'b0;
  logic [7:0]  step_a, step_b;
  logic        slowdown_en, ramp_en, coeff_wr, busy, done, timeout;
  logic [21:0] coeff_wdata;

  int checks = 0;
  int fails  = 0;
  logic [21:0] model_coeff = 22'h05_40_0C;
  logic [21:0] model_wdata = '0;
  bit          steps_seen  = 0;

  always #4 clk = ~clk;

  pll_ndiv_ramp_ctrl #(.CLK_HZ(CLK_HZ), .POLL_LIMIT(LIM)) i_pll_ndiv_ramp_ctrl (
    .clk, .rst_n, .start, .target_n, .coeff_cur, .ramp_done_sync,
    .step_a, .step_b, .slowdown_en, .ramp_en, .coeff_wdata, .coeff_wr,
    .busy, .done, .timeout);

  task automatic chk(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s: actual %0h expected %0h at %0t", req, what, act, exp, $time);
    end
  endtask

  task automatic skip_case();
    @(negedge clk);
    start = 1'b1; target_n = model_coeff[15:8]; coeff_cur = model_coeff;
    for (int t = 0; t < 4; t++) begin
      @(negedge clk);
      start = 1'b0;
      chk("R2", "done",     done,        t == 0);
      chk("R2", "busy",     busy,        0);
      chk("R2", "coeff_wr", coeff_wr,    0);
      chk("R2", "slowdown", slowdown_en, 0);
      chk("R2", "ramp_en",  ramp_en,     0);
      chk("R2", "wdata",    coeff_wdata, model_wdata);
      chk("R2", "step_a",   step_a,      steps_seen ? 8'h2B : 8'h00);
    end
  endtask

  task automatic run(input int d, input bit never, input logic [7:0] n, input bit glitch);
    int kd, k, pexit;
    bit okx;
    logic [21:0] newc;
    kd    = never ? LIM + 1 : d / U + 1;
    okx   = (kd <= LIM);
    k     = okx ? kd : LIM;
    pexit = 2 + (2 + k) * U;
    newc  = {model_coeff[21:16], n, model_coeff[7:0]};
    @(negedge clk);
    start = 1'b1; target_n = n; coeff_cur = model_coeff; ramp_done_sync = 1'b0;
    for (int t = 0; t <= pexit + 2; t++) begin
      @(negedge clk);
      start = glitch && (t == 5);
      if (glitch && t == 5) target_n = n ^ 8'h55;
      ramp_done_sync = !never && (t >= 2 + 2 * U + d) && (t < pexit);
      chk("R3", "step_a",   step_a, (t >= 1 || steps_seen) ? 8'h2B : 8'h00);
      chk("R3", "step_b",   step_b, (t >= 1 || steps_seen) ? 8'h0B : 8'h00);
      chk("R7", "slowdown", slowdown_en, t >= 2 && t < pexit);
      chk("R5", "ramp_en",  ramp_en, t >= 2 + 2 * U && t < pexit);
      chk("R4", "coeff_wr", coeff_wr, t == 2 + U);
      chk(glitch ? "R9" : "R4", "wdata", coeff_wdata, t >= 2 + U ? newc : model_wdata);
      chk("R8", "done",     done,    t == pexit + 1 && okx);
      chk("R6", "timeout",  timeout, t == pexit + 1 && !okx);
      chk("R8", "busy",     busy,    t <= pexit);
    end
    steps_seen  = 1;
    model_coeff = newc;
    model_wdata = newc;
  endtask

  initial begin
    repeat (120000) @(posedge clk);
    fails++; checks++;
    $display("FAIL watchdog: actual hung expected finished");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    int ds[12] = '{0, 1, 3, 4, 7, 8, 20, 1995, 1996, 1999, 2000, 5};
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1", "step_a",   step_a, 0);
    chk("R1", "step_b",   step_b, 0);
    chk("R1", "slowdown", slowdown_en, 0);
    chk("R1", "ramp_en",  ramp_en, 0);
    chk("R1", "wdata",    coeff_wdata, 0);
    chk("R1", "coeff_wr", coeff_wr, 0);
    chk("R1", "busy",     busy, 0);
    chk("R1", "done",     done, 0);
    chk("R1", "timeout",  timeout, 0);
    skip_case();
    for (int i = 0; i < 12; i++)
      run(ds[i], 1'b0, 8'(8'h21 + i * 8'h13), i == 6);
    skip_case();
    run(0, 1'b1, 8'hE7, 1'b0);
    run(2, 1'b0, 8'h09, 1'b1);
    skip_case();
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule